// File: doc/BRIEF.md
# Asynchronous SRAM controller

A synchronous sequencer that sits between a host issuing single-beat requests and an external asynchronous static RAM of 131,072 bytes. The host presents a request together with a direction, an address and write data, and may do so only in a cycle where `ready_o` is high. The controller then drives the memory's active-low chip enable, write enable and output enable, the address, and the data-bus direction. Each phase length is a clock-cycle count taken from a parameter, so the memory's pulse-width, setup and access limits are met at the chosen clock rate.

A write runs through three phases. The first is an address/data setup phase with the chip selected. Next comes a write-enable-low pulse. Last is a hold phase, in which write enable has risen but the data is still driven. The memory captures the byte on that rising edge. A read holds chip enable and output enable low for a fixed wait. It then samples the bus and returns the byte with a one-cycle valid strobe. The three-state data bus is split into an output, an output enable and an input, and the pad is left outside the block. The controller never drives the bus while the memory may still be driving it. After output enable rises, it waits a programmable number of released cycles before it drives write data. Between requests the memory is held in standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and whenever `ready_o` is high, the strobes `mem_ce_no`, `mem_we_no` and `mem_oe_no` are all 1 (standby), `mem_dq_oe_o` is 0, and `rvalid_o` is 0 during reset.
- R2: An accepted write (`req_i`=1, `we_i`=1 while `ready_o`=1) gives, after any turnaround cycles, SETUP_CYC cycles with ce_n=0, we_n=1, oe_n=1 and dq_oe=1. Then come WE_CYC cycles with we_n=0, and then HOLD_CYC cycles with we_n=1 and ce_n=0. During all of these cycles the latched byte is on `mem_dq_o` with dq_oe=1. `ready_o` returns high after the last phase.
- R3: An accepted read (`we_i`=0) gives exactly RD_WAIT cycles with ce_n=0, oe_n=0, we_n=1 and dq_oe=0. In the next cycle `ready_o` is 1 and `rvalid_o` is 1 for one cycle, with `rdata_o` holding the bus value of the final wait cycle.
- R4: `mem_dq_oe_o` is never 1 in a cycle where `mem_oe_no` is 0, and `mem_oe_no` and `mem_we_no` are never both 0.
- R5: Before `mem_dq_oe_o` rises, there are at least TURN_CYC cycles since the last cycle with oe_n=0 in which oe_n=1 and dq_oe=0. If a write follows a read with too few such cycles, the controller adds standby turnaround cycles, with ce_n=1 and `ready_o`=0, until the count is met. Otherwise it adds none.
- R6: `mem_addr_o` changes only at a clock edge that ends a cycle with ce_n=1. It then holds the address of the accepted request for the whole transaction, whatever `addr_i` does meanwhile.
- R7: A request presented while `ready_o` is 0 is ignored: it writes nothing and starts no transaction.
- R8: A read returns the byte most recently written to that address by the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled only while ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | Controller idle, request may be presented |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | One-cycle strobe marking rdata_o valid |
| mem_addr_o | output | AW | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DW | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DW | Data from the memory bus |

## Verification
The hardest case to reach from the ports is a write that lands while the output-enable release count is only partly used up. It needs a read that ends and a write accepted in the very cycle `ready_o` returns. A second case is a request pulsed in a busy cycle. The bench tasks issue the next request at the same sample where they see `ready_o` come back. They also add gaps of zero, one or two idle cycles, so the bench can predict the number of turnaround cycles, which is one, or zero when the gap is long enough. A directed read pulses a conflicting write request mid-transaction, and a later read of that address shows it left nothing behind.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RD
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic strobe_t strobe_of(state_e s);
    strobe_t r;
    case (s)
      ST_WSET, ST_WHLD: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WPUL:          r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_RD:            r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:          r = STB_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int HOLD_CYC  = 1,
  parameter int RD_WAIT   = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  output state_e state_q_o,
  output state_e state_d_o,
  output logic   accept_o,
  output logic   capture_o
);

  localparam int MAX_A = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAX_B = (HOLD_CYC > RD_WAIT) ? HOLD_CYC : RD_WAIT;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int QW    = $clog2(TURN_CYC + 1);
  localparam logic [QW-1:0] TURN_Q = QW'(TURN_CYC);

  state_e          state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [QW-1:0]   qcnt_q, qcnt_d;
  logic            done, turn_ok;

  function automatic logic [CW-1:0] span(state_e s);
    case (s)
      ST_WSET: return CW'(SETUP_CYC - 1);
      ST_WPUL: return CW'(WE_CYC - 1);
      ST_WHLD: return CW'(HOLD_CYC - 1);
      ST_RD:   return CW'(RD_WAIT - 1);
      default: return '0;
    endcase
  endfunction

  assign done    = (cnt_q == '0);
  // current cycle is released too, hence minus one
  assign turn_ok = (qcnt_q >= TURN_Q - 1'b1);
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RD) && done;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_i) state_d = !we_i ? ST_RD : (turn_ok ? ST_WSET : ST_TURN);
      ST_TURN: if (turn_ok) state_d = ST_WSET;
      ST_WSET: if (done) state_d = ST_WPUL;
      ST_WPUL: if (done) state_d = ST_WHLD;
      ST_WHLD: if (done) state_d = ST_IDLE;
      ST_RD:   if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state_q)  cnt_d = span(state_d);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_comb begin
    if (state_q == ST_RD)        qcnt_d = '0;
    else if (qcnt_q != TURN_Q)   qcnt_d = qcnt_q + 1'b1;
    else                         qcnt_d = qcnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      qcnt_q  <= TURN_Q;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      qcnt_q  <= qcnt_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // R3: a read always returns to idle after the sample
  a_r3_read_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> (state_q == ST_IDLE));

  // R7: a busy controller never takes a new request
  a_r7_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && (state_d == ST_RD) |-> (state_q == ST_RD));

endmodule

// File: rtl/sram_ctrl_phy.sv
module sram_ctrl_phy
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  state_e        state_d_i,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  strobe_t       stb_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  // strobes registered from next state: glitch-free pins aligned with state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q    <= STB_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      stb_q    <= strobe_of(state_d_i);
      rvalid_q <= capture_i;
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = stb_q.ce_n;
  assign mem_we_no   = stb_q.we_n;
  assign mem_oe_no   = stb_q.oe_n;
  assign mem_dq_oe_o = stb_q.dq_oe;
  assign mem_dq_o    = wdata_q;
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;

  a_r4_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);

  a_r4_oe_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  a_r6_addr_in_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> $past(mem_ce_no));

  a_r2_data_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_dq_oe_o && !mem_ce_no);

  a_r2_setup_before_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(!mem_ce_no && mem_dq_oe_o));

  a_r2_hold_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o && !mem_ce_no && $stable(mem_dq_o));

  a_r3_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int HOLD_CYC  = 1,
  parameter int RD_WAIT   = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  state_e state_q, state_d;
  logic   accept, capture;

  sram_ctrl_seq #(
    .SETUP_CYC(SETUP_CYC),
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RD_WAIT  (RD_WAIT),
    .TURN_CYC (TURN_CYC)
  ) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .state_q_o(state_q),
    .state_d_o(state_d),
    .accept_o (accept),
    .capture_o(capture)
  );

  sram_ctrl_phy #(.AW(AW), .DW(DW)) phy_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_we_no  (mem_we_no),
    .mem_oe_no  (mem_oe_no),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assign ready_o = (state_q == ST_IDLE);

  // R1: idle means standby with the bus released
  a_r1_standby_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_ce_no && mem_we_no && mem_oe_no && !mem_dq_oe_o);

endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

  localparam int AW = 17, DW = 8;
  localparam int SETUP = 1, WEC = 2, HOLD = 1, RDW = 2, TURN = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni, req, we, ready, rvalid;
  logic [AW-1:0] addr, mem_addr;
  logic [DW-1:0] wdata, rdata, mem_dq_o, mem_dq_i;
  logic          ce_n, we_n, oe_n, dq_oe;

  sram_ctrl #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP), .WE_CYC(WEC),
    .HOLD_CYC(HOLD), .RD_WAIT(RDW), .TURN_CYC(TURN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
  endfunction

  // behavioural memory: captures on the rising write strobe
  logic [7:0] model [logic [AW-1:0]];
  logic [7:0] refm  [logic [AW-1:0]];
  int model_bad = 0;

  always @(posedge we_n) begin
    if (rst_ni && !ce_n) begin
      if (!dq_oe) model_bad++;
      model[mem_addr] = mem_dq_o;
    end
  end

  always @* begin
    if (!ce_n && !oe_n && we_n)
      mem_dq_i = model.exists(mem_addr) ? model[mem_addr] : init_val(mem_addr);
    else
      mem_dq_i = 8'h00;
  end

  function automatic logic [7:0] ref_val(logic [AW-1:0] a);
    return refm.exists(a) ? refm[a] : init_val(a);
  endfunction

  // cycle monitor
  int r1_bad = 0, r3_bad = 0, r4_bad = 0, r5_bad = 0, r6_bad = 0;
  int quiet = TURN;
  logic p_dq_oe = 0, p_ce_n = 1, p_rvalid = 0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      quiet = TURN; p_dq_oe = 0; p_ce_n = 1; p_rvalid = 0; p_addr = mem_addr;
    end else begin
      if (ready && !(ce_n && we_n && oe_n && !dq_oe)) r1_bad++;
      if ((!oe_n && dq_oe) || (!oe_n && !we_n)) r4_bad++;
      if (dq_oe && !p_dq_oe && quiet < TURN) r5_bad++;
      if (mem_addr != p_addr && !p_ce_n) r6_bad++;
      if (rvalid && (p_rvalid || !ready)) r3_bad++;
      if (!oe_n) quiet = 0;
      else if (!dq_oe) quiet++;
      p_dq_oe = dq_oe; p_ce_n = ce_n; p_rvalid = rvalid; p_addr = mem_addr;
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, output int turns);
    int set = 0, pul = 0, hld = 0;
    bit shape_ok = 1, addr_ok = 1, data_ok = 1;
    turns = 0;
    while (!ready) @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; addr = ~a; wdata = ~d;
    while (!ready) begin
      if (ce_n) begin
        turns++;
        if (set + pul + hld != 0 || dq_oe) shape_ok = 0;
      end else begin
        if (!oe_n || !dq_oe) shape_ok = 0;
        if (mem_addr != a) addr_ok = 0;
        if (mem_dq_o != d) data_ok = 0;
        if (!we_n) begin pul++; if (hld != 0) shape_ok = 0; end
        else if (pul == 0) set++;
        else hld++;
      end
      @(negedge clk);
    end
    chk(shape_ok, "R2 write strobe shape", {31'b0, shape_ok}, 1);
    chk(set == SETUP && pul == WEC && hld == HOLD, "R2 write phase lengths",
        {8'(set), 8'(pul), 8'(hld)}, {8'(SETUP), 8'(WEC), 8'(HOLD)});
    chk(data_ok, "R2 write data on bus", {24'b0, mem_dq_o}, {24'b0, d});
    chk(addr_ok, "R6 write address held", {15'b0, mem_addr}, {15'b0, a});
    refm[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit inject);
    int rc = 0;
    bit shape_ok = 1, addr_ok = 1;
    logic [7:0] exp;
    while (!ready) @(negedge clk);
    exp = ref_val(a);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    if (inject) begin req = 1; we = 1; addr = a ^ 17'h1; wdata = 8'hA5; end
    else begin req = 0; addr = ~a; end
    while (!ready) begin
      if (ce_n || oe_n || !we_n || dq_oe) shape_ok = 0;
      if (mem_addr != a) addr_ok = 0;
      rc++;
      @(negedge clk);
      req = 0; we = 0;
    end
    chk(shape_ok && rc == RDW, "R3 read strobes and wait", rc, RDW);
    chk(rvalid === 1'b1, "R3 rvalid with ready", {31'b0, rvalid}, 1);
    chk(rdata === exp, "R8 read data", {24'b0, rdata}, {24'b0, exp});
    chk(addr_ok, "R6 read address held", {15'b0, mem_addr}, {15'b0, a});
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  logic [AW-1:0] pool [16];

  initial begin
    int t;
    void'($urandom(32'h5eed_1025));
    rst_ni = 0; req = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ce_n && we_n && oe_n, "R1 strobes high in reset", {29'b0, ce_n, we_n, oe_n}, 7);
    chk(!dq_oe && !rvalid && ready, "R1 bus released, ready", {29'b0, dq_oe, rvalid, ready}, 1);
    rst_ni = 1;
    @(negedge clk);

    do_write(17'h1ABCD, 8'h5A, t);
    chk(t == 0, "R5 no turnaround from idle", t, 0);
    do_read(17'h1ABCD, 0);
    do_write(17'h00010, 8'h33, t);            // write right after read
    chk(t == 1, "R5 turnaround after read", t, 1);
    do_read(17'h00010, 0);
    @(negedge clk);                            // one extra released cycle
    do_write(17'h00011, 8'hC4, t);
    chk(t == 0, "R5 gap covers turnaround", t, 0);
    do_write(17'h00012, 8'h0F, t);
    chk(t == 0, "R5 write after write", t, 0);
    do_read(17'h1FFFF, 0);                     // unwritten top address
    do_read(17'h00000, 0);
    do_write(17'h00020, 8'h77, t);
    do_write(17'h00021, 8'h88, t);
    do_read(17'h00020, 1);                     // R7: busy request injected
    do_read(17'h00021, 0);
    chk(model_bad == 0, "R7 no write from busy request", model_bad, 0);

    for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
    pool[0] = '0; pool[1] = '1;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = pool[$urandom_range(0, 15)];
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom), t);
      else do_read(a, ($urandom_range(0, 7) == 0));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    chk(r1_bad == 0, "R1 standby whenever ready", r1_bad, 0);
    chk(r3_bad == 0, "R3 rvalid single cycle", r3_bad, 0);
    chk(r4_bad == 0, "R4 no bus contention", r4_bad, 0);
    chk(r5_bad == 0, "R5 release count before drive", r5_bad, 0);
    chk(r6_bad == 0, "R6 address moves only in standby", r6_bad, 0);
    chk(model_bad == 0, "R2 data driven at write end", model_bad, 0);
    summary();
  end

endmodule